// File: doc/BRIEF.md
# Multi-Output Clock Divider Bank

This block takes one fast oscillator clock and derives four slower clocks from it with integer counters. Output A runs at a fixed ratio of 16. Outputs B and C each run at one of two ratios, 20 or 25. A two-bit code stands for a three-level board pin and selects the ratios. Both outputs can be set fast, both slow, or B fast and C slow. The mixed setting is what the pin gives when left floating. Output D divides by 75 to give a slow processor clock, and a hold input can park it low.

Two of the ratios are odd (25 and 75). They still give an even duty cycle, because a falling-edge copy of the high phase stretches each pulse by half an input cycle. New ratios and the hold request take effect only at the boundary between two output periods. No output ever produces a shortened pulse. The block also carries a source-select flag through one register for the logic that picks the oscillator reference. All asynchronous control inputs are synchronized inside the block. The reset is asynchronous active-low with synchronous release. After release, all four outputs rise on the same input edge.

Top module: `clk_div_bank`

## Requirements
- R1: While reset is asserted, clk_a, clk_b, clk_c and clk_d are low and ref_use_xtal is high.
- R2: After reset is released, the first rising edge of all four outputs occurs on the same input clock edge.
- R3: clk_a has a period of 16 input cycles and stays high for 8 of them.
- R4: freq_sel code 00 sets B and C both to ratio 20. Code 01 sets both to ratio 25. Codes 10 and 11 set B to ratio 20 and C to ratio 25.
- R5: An output with odd ratio N stays high for exactly N half-cycles of the input clock out of a period of 2N half-cycles. This applies to ratios 25 and 75.
- R6: clk_d has a period of 75 input cycles.
- R7: A change of freq_sel takes effect only at an output period boundary. Every period of B and C seen during a change is a complete period of either the old ratio or the new one.
- R8: While force_low is held, clk_d stays low. Assertion and release take effect only at a clk_d period boundary, so a pulse already in progress completes at full length.
- R9: ref_use_xtal equals ref_sel as sampled on the previous rising clock edge (1 selects the crystal path, 0 the external reference).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco | input | 1 | High-rate source clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| freq_sel | input | 2 | Ratio code for B and C: 00 both fast, 01 both slow, 10/11 mixed |
| force_low | input | 1 | Parks clk_d low while high |
| ref_sel | input | 1 | Reference source choice, 1 = crystal, 0 = external clock |
| ref_use_xtal | output | 1 | Registered copy of ref_sel for the reference multiplexer |
| clk_a | output | 1 | Source divided by 16 |
| clk_b | output | 1 | Source divided by 20 or 25 |
| clk_c | output | 1 | Source divided by 20 or 25 |
| clk_d | output | 1 | Source divided by 75, can be held low |

## Verification
All four freq_sel codes are applied in turn. Periods and high times are measured with half-cycle resolution. This separates a correct odd-ratio stretch from a one-cycle-short or one-cycle-long pulse, and it distinguishes code 11 from code 01. A ratio change is applied right after a rising edge of B, in the middle of a period. Three periods are then measured, so that any mixed-length or runt period would show up. force_low is raised in the middle of a clk_d high pulse: the bench checks that this pulse completes at full length, that clk_d then stays flat, and that a clean period follows release.

// File: rtl/clk_div_pkg.sv
package clk_div_pkg;

  typedef enum logic [1:0] {
    FS_LOW    = 2'b00,
    FS_HIGH   = 2'b01,
    FS_FLOAT  = 2'b10,
    FS_FLOAT2 = 2'b11
  } freq_mode_e;

  localparam int unsigned NUM_OUTS = 4;
  localparam int unsigned SYNC_DEPTH = 2;

endpackage

// File: rtl/clk_div_sel_decode.sv
module clk_div_sel_decode
  import clk_div_pkg::*;
#(
  parameter int unsigned CNT_W = 7,
  parameter int unsigned FAST  = 20,
  parameter int unsigned SLOW  = 25
) (
  input  logic [1:0]       sel,
  output logic [CNT_W-1:0] ratio_b,
  output logic [CNT_W-1:0] ratio_c
);

  localparam logic [CNT_W-1:0] R_FAST = CNT_W'(FAST);
  localparam logic [CNT_W-1:0] R_SLOW = CNT_W'(SLOW);

  always_comb begin
    unique case (freq_mode_e'(sel))
      FS_LOW: begin
        ratio_b = R_FAST;
        ratio_c = R_FAST;
      end
      FS_HIGH: begin
        ratio_b = R_SLOW;
        ratio_c = R_SLOW;
      end
      default: begin
        ratio_b = R_FAST;
        ratio_c = R_SLOW;
      end
    endcase
  end

endmodule

// File: rtl/clk_div_core.sv
module clk_div_core #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] ratio_req,
  input  logic             hold,
  output logic             clk_out
);

  logic             run_q;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [CNT_W-1:0] ratio_q, ratio_nxt;
  logic [CNT_W-1:0] half_nxt;
  logic             hold_q, hold_nxt;
  logic             p_q, p_nxt;
  logic             n_q;
  logic             term;
  logic             load;

  // next-state: ratio and hold are only taken at a period boundary
  always_comb begin
    term = (cnt_q == ratio_q - 1'b1);
    load = !run_q || term;
    if (load) begin
      ratio_nxt = ratio_req;
      hold_nxt  = hold;
      cnt_nxt   = '0;
    end else begin
      ratio_nxt = ratio_q;
      hold_nxt  = hold_q;
      cnt_nxt   = cnt_q + 1'b1;
    end
    half_nxt = ratio_nxt >> 1;
    p_nxt    = (cnt_nxt < half_nxt) && !hold_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      ratio_q <= '0;
      hold_q  <= 1'b0;
      p_q     <= 1'b0;
    end else begin
      run_q   <= 1'b1;
      cnt_q   <= cnt_nxt;
      ratio_q <= ratio_nxt;
      hold_q  <= hold_nxt;
      p_q     <= p_nxt;
    end
  end

  // half-cycle stretch, only active for odd ratios
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) n_q <= 1'b0;
    else        n_q <= p_q & ratio_q[0];
  end

  assign clk_out = p_q | n_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q < ratio_q));  // R7
  AST_RATIO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && (cnt_q != ratio_q - 1'b1)) |=> $stable(ratio_q));  // R7
  AST_WRAP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && (cnt_q == ratio_q - 1'b1)) |-> !p_q);  // R5
  AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> !(p_q || n_q));  // R8

endmodule

// File: rtl/clk_div_bank.sv
module clk_div_bank
  import clk_div_pkg::*;
#(
  parameter int unsigned DIV_A    = 16,
  parameter int unsigned DIV_FAST = 20,
  parameter int unsigned DIV_SLOW = 25,
  parameter int unsigned DIV_D    = 75
) (
  input  logic       clk_vco,
  input  logic       rst_n,
  input  logic [1:0] freq_sel,
  input  logic       force_low,
  input  logic       ref_sel,
  output logic       ref_use_xtal,
  output logic       clk_a,
  output logic       clk_b,
  output logic       clk_c,
  output logic       clk_d
);

  localparam int unsigned MAX_AB  = (DIV_A > DIV_SLOW) ? DIV_A : DIV_SLOW;
  localparam int unsigned MAX_ABF = (MAX_AB > DIV_FAST) ? MAX_AB : DIV_FAST;
  localparam int unsigned MAXDIV  = (MAX_ABF > DIV_D) ? MAX_ABF : DIV_D;
  localparam int unsigned CNT_W   = $clog2(MAXDIV + 1);

  // reset: asynchronous assert, synchronous release
  logic [SYNC_DEPTH-1:0] rst_sync_q;
  logic                  rst_n_s;

  always_ff @(posedge clk_vco or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_DEPTH-2:0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[SYNC_DEPTH-1];

  // control synchronizers
  logic [SYNC_DEPTH-1:0][1:0] sel_sync_q;
  logic [SYNC_DEPTH-1:0]      frc_sync_q;
  logic                       ref_q;

  always_ff @(posedge clk_vco or negedge rst_n_s) begin
    if (!rst_n_s) begin
      sel_sync_q <= {SYNC_DEPTH{FS_FLOAT}};
      frc_sync_q <= '0;
      ref_q      <= 1'b1;
    end else begin
      sel_sync_q <= {sel_sync_q[SYNC_DEPTH-2:0], freq_sel};
      frc_sync_q <= {frc_sync_q[SYNC_DEPTH-2:0], force_low};
      ref_q      <= ref_sel;
    end
  end
  assign ref_use_xtal = ref_q;

  logic [CNT_W-1:0] ratio_b, ratio_c;

  clk_div_sel_decode #(
    .CNT_W (CNT_W),
    .FAST  (DIV_FAST),
    .SLOW  (DIV_SLOW)
  ) u_decode (
    .sel     (sel_sync_q[SYNC_DEPTH-1]),
    .ratio_b (ratio_b),
    .ratio_c (ratio_c)
  );

  logic [CNT_W-1:0]    ratio_v [NUM_OUTS];
  logic [NUM_OUTS-1:0] hold_v;
  logic [NUM_OUTS-1:0] out_v;

  assign ratio_v[0] = CNT_W'(DIV_A);
  assign ratio_v[1] = ratio_b;
  assign ratio_v[2] = ratio_c;
  assign ratio_v[3] = CNT_W'(DIV_D);
  assign hold_v     = {frc_sync_q[SYNC_DEPTH-1], 3'b000};

  for (genvar gi = 0; gi < NUM_OUTS; gi++) begin : g_div
    clk_div_core #(
      .CNT_W (CNT_W)
    ) u_core (
      .clk       (clk_vco),
      .rst_n     (rst_n_s),
      .ratio_req (ratio_v[gi]),
      .hold      (hold_v[gi]),
      .clk_out   (out_v[gi])
    );
  end

  assign clk_a = out_v[0];
  assign clk_b = out_v[1];
  assign clk_c = out_v[2];
  assign clk_d = out_v[3];

  AST_REF_FOLLOW: assert property (@(posedge clk_vco) disable iff (!rst_n_s)
    1'b1 |=> (ref_use_xtal == $past(ref_sel)));  // R9

endmodule

// File: tb/clk_div_bank_tb_top.sv
`timescale 1ns/1ps
module clk_div_bank_tb_top;

  logic       clk_vco;
  logic       rst_n;
  logic [1:0] freq_sel;
  logic       force_low;
  logic       ref_sel;
  logic       ref_use_xtal;
  logic       clk_a, clk_b, clk_c, clk_d;

  int n_checks;
  int n_fail;

  clk_div_bank dut_i (
    .clk_vco      (clk_vco),
    .rst_n        (rst_n),
    .freq_sel     (freq_sel),
    .force_low    (force_low),
    .ref_sel      (ref_sel),
    .ref_use_xtal (ref_use_xtal),
    .clk_a        (clk_a),
    .clk_b        (clk_b),
    .clk_c        (clk_c),
    .clk_d        (clk_d)
  );

  initial clk_vco = 1'b0;
  always #2 clk_vco = ~clk_vco;  // 250 MHz

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // advance to the middle of the next half cycle
  task automatic step();
    @(clk_vco);
    #1;
  endtask

  function automatic logic pick(input int w);
    case (w)
      0: return clk_a;
      1: return clk_b;
      2: return clk_c;
      default: return clk_d;
    endcase
  endfunction

  // one full period from rising edge to rising edge, in half cycles
  task automatic measure(input int w, output int hi, output int per);
    logic prev, cur, rise;
    int guard;
    prev  = pick(w);
    guard = 0;
    rise  = 1'b0;
    cur   = prev;
    while (!rise && guard < 2000) begin
      step();
      cur  = pick(w);
      rise = !prev && cur;
      prev = cur;
      guard++;
    end
    hi   = 0;
    per  = 0;
    rise = 1'b0;
    while (!rise && per < 2000) begin
      hi  += int'(cur);
      per++;
      step();
      cur  = pick(w);
      rise = !prev && cur;
      prev = cur;
    end
  endtask

  task automatic wait_halves(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic t_reset_and_start();
    int guard;
    rst_n = 1'b0;
    wait_halves(10);
    check(!clk_a && !clk_b && !clk_c && !clk_d, "R1 outputs low in reset",
          int'({clk_a, clk_b, clk_c, clk_d}), 0);
    check(ref_use_xtal == 1'b1, "R1 ref flag in reset", int'(ref_use_xtal), 1);
    rst_n = 1'b1;
    guard = 0;
    while (!(clk_a || clk_b || clk_c || clk_d) && guard < 100) begin
      step();
      guard++;
    end
    check(clk_a && clk_b && clk_c && clk_d, "R2 all outputs rise together",
          int'({clk_a, clk_b, clk_c, clk_d}), 15);
  endtask

  task automatic t_out_a();
    int hi, per;
    measure(0, hi, per);
    check(per == 32, "R3 clk_a period", per, 32);
    check(hi == 16, "R3 clk_a high time", hi, 16);
  endtask

  task automatic t_mode(input logic [1:0] code, input int eb, input int ec, input string tag);
    int hi, per;
    freq_sel = code;
    wait_halves(120);
    measure(1, hi, per);
    check(per == 2 * eb, {tag, " clk_b period"}, per, 2 * eb);
    check(hi == eb, {tag, " clk_b high"}, hi, eb);
    measure(2, hi, per);
    check(per == 2 * ec, {tag, " clk_c period"}, per, 2 * ec);
    check(hi == ec, {tag, " clk_c high (R5 when odd)"}, hi, ec);
  endtask

  task automatic t_out_d();
    int hi, per;
    measure(3, hi, per);
    check(per == 150, "R6 clk_d period", per, 150);
    check(hi == 75, "R5 clk_d high over odd ratio", hi, 75);
  endtask

  task automatic t_change_midperiod();
    int hi, per;
    freq_sel = 2'b00;
    wait_halves(120);
    while (clk_b) step();
    while (!clk_b) step();
    wait_halves(6);
    freq_sel = 2'b01;  // mid high pulse of clk_b
    for (int k = 0; k < 3; k++) begin
      measure(1, hi, per);
      check(per == 40 || per == 50, "R7 whole period during change", per, 50);
      check(2 * hi == per, "R7 no runt pulse during change", hi, per / 2);
    end
  endtask

  task automatic t_force_low();
    int hi, per, hi_cnt, rises;
    logic prev;
    while (clk_d) step();
    while (!clk_d) step();
    hi_cnt = 1;
    wait_halves(10);
    hi_cnt += 10;
    force_low = 1'b1;
    while (clk_d) begin
      step();
      hi_cnt += int'(clk_d);
    end
    check(hi_cnt == 75, "R8 pulse in progress completes", hi_cnt, 75);
    wait_halves(200);
    rises = 0;
    prev  = clk_d;
    for (int i = 0; i < 400; i++) begin
      step();
      if (clk_d) rises++;
      prev = clk_d;
    end
    check(rises == 0 && !prev, "R8 clk_d parked low", rises, 0);
    force_low = 1'b0;
    measure(3, hi, per);
    measure(3, hi, per);
    check(per == 150 && hi == 75, "R8 clean period after release", hi, 75);
  endtask

  task automatic t_ref();
    @(negedge clk_vco); #1;
    ref_sel = 1'b0;
    @(posedge clk_vco); #1;
    check(ref_use_xtal == 1'b0, "R9 external reference flag", int'(ref_use_xtal), 0);
    @(negedge clk_vco); #1;
    ref_sel = 1'b1;
    @(posedge clk_vco); #1;
    check(ref_use_xtal == 1'b1, "R9 crystal flag", int'(ref_use_xtal), 1);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    #400000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    n_checks  = 0;
    n_fail    = 0;
    rst_n     = 1'b0;
    freq_sel  = 2'b10;
    force_low = 1'b0;
    ref_sel   = 1'b1;
    #1;
    t_reset_and_start();
    t_out_a();
    t_mode(2'b10, 20, 25, "R4 code 10");
    t_out_d();
    t_mode(2'b00, 20, 20, "R4 code 00");
    t_mode(2'b01, 25, 25, "R4 code 01");
    t_mode(2'b11, 20, 25, "R4 code 11");
    t_change_midperiod();
    t_force_low();
    t_ref();
    summary();
    $finish;
  end

endmodule